// File: doc/BRIEF.md
# Power-Domain Gating Sequencer

This block switches a set of gateable power domains off and on at the request of software. Software reaches it through a plain 32-bit register bus with word addresses. One shared control word holds a pair of request bits per domain. The power-down bit of a domain sits at a fixed position, and its power-up bit is the bit directly above it. Each domain also owns a group of three words: a gating permission bit, the delay pair used when powering up, and the delay pair used when powering down.

When a request is seen, the domain's sequencer drives two outputs in a safe order. The power switch enable is driven high to supply the domain. The isolation enable is driven high to clamp the domain's outputs. Each sequence has two timed phases, and each phase counts peripheral-clock cycles, which arrive as single-cycle pulses on `periph_tick`. On power-up the switch closes first and isolation is lifted last. On power-down isolation is applied first and the switch opens last. When a sequence ends, its request bit clears itself, so software polls the control word to learn when the sequence is done. A read-only status bit per domain reports whether the domain is powered off.

Top module: `pgseq_top`

## Requirements
- R1: After reset every domain has its switch enable at 1 and its isolation enable at 0, and the control word at address 0x000 reads 0.
- R2: Domain 0 owns control bits 0 (power-down request), 1 (power-up request) and 2 (read-only status, 1 = powered off), with its register group at 0x260. Domain 1 owns control bits 4, 5 and 6, with its group at 0x240. Within a group, +0x0 bit 0 is the gating permission, +0x4 is the power-up delay pair and +0x8 is the power-down delay pair. A delay pair holds the first-phase count in bits [5:0] and the second-phase count in bits [13:8]. Every other bit reads back 0.
- R3: A read returns data only for a word-aligned address no higher than 0x2ac. Any other address, and any unmapped aligned address, reads 0.
- R4: Take a power-down request written at a clock edge, with the permission bit set and power-down delays a (bits [5:0]) and b (bits [13:8]). Isolation goes high at the next edge with the switch still on. The switch turns off, the request bit clears and the status bit reads 1 exactly a+b+2 edges after isolation went high.
- R5: Take a power-up request written at a clock edge, with power-up delays a and b. The switch goes on at the next edge. Isolation drops and the request bit clears exactly a+b+2 edges after that.
- R6: A power-down request for a domain whose permission bit is 0 leaves both outputs unchanged, and its bit reads 0 one edge later.
- R7: If one write sets both request bits of a domain, the power-up sequence runs and the power-down bit reads 0 one edge later.
- R8: While a domain has a request pending or a sequence running, new request writes to that domain are discarded. Writing 0 to a request bit never clears it. Requests for the other domain are still accepted.
- R9: Delay counting advances only on cycles where `periph_tick` is 1. With nonzero delays and the tick held low, a sequence holds in its first phase.
- R10: A domain's isolation enable is always 1 whenever its switch enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| periph_tick | input | 1 | One pulse per peripheral-clock cycle |
| dom_switch_en | output | NUM_DOM (2) | Power switch enable per domain |
| dom_iso_en | output | NUM_DOM (2) | Isolation enable per domain |

## Verification
The bench builds the block with NUM_DOM = 2 and 12 address bits. This places both register groups and all six control bits at the positions the requirements fix, so the bench can exercise two domains working against each other, with one busy while the other accepts a request. It uses 6-bit delay fields. With those widths, the longest sequence, 63+63 counts, fits in about 130 edges, so the bench can check the zero-delay and full-scale corners with exact edge counts. It also stalls the tick to show that counting advances only on tick cycles.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

    localparam int DLY_W       = 6;
    localparam int FIELD2_LSB  = 8;
    localparam int LAST_ADDR   = 'h2ac;
    localparam int TOP_GRP     = 'h260;
    localparam int GRP_STRIDE  = 'h20;
    localparam int BITS_PER_DOM = 4;

    typedef struct packed {
        logic [DLY_W-1:0] late;
        logic [DLY_W-1:0] early;
    } delay_pair_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UP_A,
        S_UP_B,
        S_DN_A,
        S_DN_B
    } seq_state_e;

    // Byte address of a domain's register group.
    function automatic int grp_base(input int d);
        return TOP_GRP - GRP_STRIDE * d;
    endfunction

    // Position of a domain's power-down request bit; up is +1, status +2.
    function automatic int dn_pos(input int d);
        return BITS_PER_DOM * d;
    endfunction

    function automatic logic [31:0] pair_to_word(input delay_pair_t p);
        logic [31:0] w;
        w = '0;
        w[DLY_W-1:0] = p.early;
        w[FIELD2_LSB +: DLY_W] = p.late;
        return w;
    endfunction

    function automatic delay_pair_t word_to_pair(input logic [31:0] w);
        delay_pair_t p;
        p.early = w[DLY_W-1:0];
        p.late  = w[FIELD2_LSB +: DLY_W];
        return p;
    endfunction

endpackage

// File: rtl/pgseq_regs.sv
module pgseq_regs
    import pgseq_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_DOM-1:0] dom_busy,
    input  logic [NUM_DOM-1:0] dom_off,
    input  logic [NUM_DOM-1:0] clr_up,
    input  logic [NUM_DOM-1:0] clr_dn,
    output logic [NUM_DOM-1:0] req_up,
    output logic [NUM_DOM-1:0] req_dn,
    output logic [NUM_DOM-1:0] gate_en,
    output delay_pair_t       up_dly [NUM_DOM],
    output delay_pair_t       dn_dly [NUM_DOM]
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

    logic aligned;
    logic ctrl_wr;
    logic [31:0] ctrl_word;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ctrl_wr = bus_wr && aligned && (bus_addr == '0);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        localparam int BASE = grp_base(d);
        localparam int DNB  = dn_pos(d);

        logic hit_gate, hit_up, hit_dn, set_ok;

        assign hit_gate = bus_wr && (bus_addr == ADDR_W'(BASE));
        assign hit_up   = bus_wr && (bus_addr == ADDR_W'(BASE + 4));
        assign hit_dn   = bus_wr && (bus_addr == ADDR_W'(BASE + 8));
        assign set_ok   = ctrl_wr && !dom_busy[d] && !req_up[d] && !req_dn[d];

        always_ff @(posedge clk) begin
            if (rst) begin
                gate_en[d] <= 1'b0;
                up_dly[d]  <= '0;
                dn_dly[d]  <= '0;
                req_up[d]  <= 1'b0;
                req_dn[d]  <= 1'b0;
            end else begin
                if (hit_gate) gate_en[d] <= bus_wdata[0];
                if (hit_up)   up_dly[d]  <= word_to_pair(bus_wdata);
                if (hit_dn)   dn_dly[d]  <= word_to_pair(bus_wdata);
                req_up[d] <= (req_up[d] | (set_ok & bus_wdata[DNB+1])) & ~clr_up[d];
                req_dn[d] <= (req_dn[d] | (set_ok & bus_wdata[DNB]))   & ~clr_dn[d];
            end
        end

        // R8: a running sequence never carries both requests of its domain
        p_busy_single_req_r8: assert property (@(posedge clk) disable iff (rst)
            dom_busy[d] |-> !(req_up[d] && req_dn[d]));

        // R8: while busy, the power-up bit changes only by its own completion
        p_busy_hold_up_r8: assert property (@(posedge clk) disable iff (rst)
            ($past(dom_busy[d]) && !$past(clr_up[d])) |-> (req_up[d] == $past(req_up[d])));
    end

    always_comb begin
        ctrl_word = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            ctrl_word[dn_pos(d)]     = req_dn[d];
            ctrl_word[dn_pos(d) + 1] = req_up[d];
            ctrl_word[dn_pos(d) + 2] = dom_off[d];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned && (bus_addr <= LAST)) begin
            if (bus_addr == '0) bus_rdata = ctrl_word;
            for (int d = 0; d < NUM_DOM; d++) begin
                if (bus_addr == ADDR_W'(grp_base(d)))
                    bus_rdata = {31'b0, gate_en[d]};
                if (bus_addr == ADDR_W'(grp_base(d) + 4))
                    bus_rdata = pair_to_word(up_dly[d]);
                if (bus_addr == ADDR_W'(grp_base(d) + 8))
                    bus_rdata = pair_to_word(dn_dly[d]);
            end
        end
    end

endmodule

// File: rtl/pgseq_domain.sv
module pgseq_domain
    import pgseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        gate_en,
    input  logic        req_up,
    input  logic        req_dn,
    input  delay_pair_t up_dly,
    input  delay_pair_t dn_dly,
    output logic        switch_en,
    output logic        iso_en,
    output logic        busy,
    output logic        clr_up,
    output logic        clr_dn
);

    seq_state_e       state;
    logic [DLY_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);
    assign busy     = (state != S_IDLE);

    // Completion clears the active request; power-up beats power-down;
    // a power-down without permission is dropped.
    assign clr_up = (state == S_UP_B) && cnt_zero;
    assign clr_dn = ((state == S_DN_B) && cnt_zero) ||
                    ((state == S_IDLE) && req_dn && (req_up || !gate_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            switch_en <= 1'b1;
            iso_en    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_up) begin
                        state     <= S_UP_A;
                        cnt       <= up_dly.early;
                        switch_en <= 1'b1;
                    end else if (req_dn && gate_en) begin
                        state  <= S_DN_A;
                        cnt    <= dn_dly.early;
                        iso_en <= 1'b1;
                    end
                end
                S_UP_A: begin
                    if (cnt_zero) begin
                        state <= S_UP_B;
                        cnt   <= up_dly.late;
                    end else if (tick) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_UP_B: begin
                    if (cnt_zero) begin
                        state  <= S_IDLE;
                        iso_en <= 1'b0;
                    end else if (tick) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_DN_A: begin
                    if (cnt_zero) begin
                        state <= S_DN_B;
                        cnt   <= dn_dly.late;
                    end else if (tick) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_DN_B: begin
                    if (cnt_zero) begin
                        state     <= S_IDLE;
                        switch_en <= 1'b0;
                    end else if (tick) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_iso_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !switch_en |-> iso_en);

    p_switch_on_isolated_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(switch_en) |-> iso_en);

    p_release_powered_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(iso_en) |-> switch_en);

    p_clr_up_pending_r8: assert property (@(posedge clk) disable iff (rst)
        clr_up |-> req_up);

    p_clr_dn_pending_r6: assert property (@(posedge clk) disable iff (rst)
        clr_dn |-> req_dn);

endmodule

// File: rtl/pgseq_top.sv
module pgseq_top
    import pgseq_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               periph_tick,
    output logic [NUM_DOM-1:0] dom_switch_en,
    output logic [NUM_DOM-1:0] dom_iso_en
);

    logic [NUM_DOM-1:0] busy, off, clr_up, clr_dn, req_up, req_dn, gate_en;
    delay_pair_t        up_dly [NUM_DOM];
    delay_pair_t        dn_dly [NUM_DOM];

    assign off = ~dom_switch_en;

    pgseq_regs #(
        .NUM_DOM (NUM_DOM),
        .ADDR_W  (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dom_busy  (busy),
        .dom_off   (off),
        .clr_up    (clr_up),
        .clr_dn    (clr_dn),
        .req_up    (req_up),
        .req_dn    (req_dn),
        .gate_en   (gate_en),
        .up_dly    (up_dly),
        .dn_dly    (dn_dly)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_seq
        pgseq_domain seq_i (
            .clk       (clk),
            .rst       (rst),
            .tick      (periph_tick),
            .gate_en   (gate_en[d]),
            .req_up    (req_up[d]),
            .req_dn    (req_dn[d]),
            .up_dly    (up_dly[d]),
            .dn_dly    (dn_dly[d]),
            .switch_en (dom_switch_en[d]),
            .iso_en    (dom_iso_en[d]),
            .busy      (busy[d]),
            .clr_up    (clr_up[d]),
            .clr_dn    (clr_dn[d])
        );
    end

endmodule

// File: tb/pgseq_top_tb_top.sv
`timescale 1ns/1ps
module pgseq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        periph_tick = 1'b1;
    logic [1:0]  dom_switch_en;
    logic [1:0]  dom_iso_en;

    int n_checks = 0;
    int n_fail   = 0;
    int iso_viol = 0;

    always #4 clk = ~clk;

    pgseq_top dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .periph_tick   (periph_tick),
        .dom_switch_en (dom_switch_en),
        .dom_iso_en    (dom_iso_en)
    );

    // R10 monitor: isolation must be up whenever the switch is off
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++)
                if (!dom_switch_en[i] && !dom_iso_en[i]) iso_viol++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // Runs one sequence for domain d and checks its edge-exact timing.
    task automatic run_seq(input int d, input bit up, input int a, input int b, input string req);
        logic [31:0] r;
        int n;
        int pos;
        pos = 4 * d + (up ? 1 : 0);
        wr(12'h000, 32'(1) << pos);
        step(1);
        if (up) chk(dom_switch_en[d] == 1'b1 && dom_iso_en[d] == 1'b1, req, {dom_switch_en[d], dom_iso_en[d]}, 2'b11);
        else    chk(dom_switch_en[d] == 1'b1 && dom_iso_en[d] == 1'b1, req, {dom_switch_en[d], dom_iso_en[d]}, 2'b11);
        n = 0;
        while (n < 300 && (up ? (dom_iso_en[d] == 1'b1) : (dom_switch_en[d] == 1'b1))) begin
            step(1);
            n++;
        end
        chk(n == a + b + 2, req, n, a + b + 2);
        rd(12'h000, r);
        chk(r[pos] == 1'b0 && r[4*d+2] == !up, req, r[4*d +: 3], {!up, 2'b00});
    endtask

    task automatic t_reset();
        logic [31:0] r;
        rd(12'h000, r);
        chk(r == 32'h0, "R1", r, 0);
        chk(dom_switch_en == 2'b11 && dom_iso_en == 2'b00, "R1", {dom_switch_en, dom_iso_en}, 4'b1100);
    endtask

    task automatic t_regmap();
        logic [31:0] r;
        wr(12'h260, 32'hffff_ffff);
        rd(12'h260, r); chk(r == 32'h1, "R2", r, 1);
        wr(12'h264, 32'hffff_ffff);
        rd(12'h264, r); chk(r == 32'h3f3f, "R2", r, 32'h3f3f);
        wr(12'h248, 32'h0000_2a15);
        rd(12'h248, r); chk(r == 32'h2a15, "R2", r, 32'h2a15);
        rd(12'h240, r); chk(r == 32'h0, "R2", r, 0);
        rd(12'h262, r); chk(r == 32'h0, "R3", r, 0);
        rd(12'h2b0, r); chk(r == 32'h0, "R3", r, 0);
        rd(12'h004, r); chk(r == 32'h0, "R3", r, 0);
    endtask

    task automatic t_gate_blocked();
        logic [31:0] r;
        wr(12'h260, 32'h0);
        wr(12'h000, 32'h1);
        step(1);
        rd(12'h000, r);
        chk(r[0] == 1'b0, "R6", r[0], 0);
        chk(dom_switch_en[0] && !dom_iso_en[0], "R6", {dom_switch_en[0], dom_iso_en[0]}, 2'b10);
    endtask

    task automatic t_both_bits();
        logic [31:0] r;
        wr(12'h000, 32'h3);
        step(1);
        rd(12'h000, r);
        chk(r[1:0] == 2'b10 && dom_switch_en[0], "R7", r[1:0], 2'b10);
        step(20);
        chk(dom_iso_en[0] == 1'b0, "R7", dom_iso_en[0], 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] r;
        wr(12'h240, 32'h1);
        wr(12'h24c - 12'h4, 32'h0);
        wr(12'h000, 32'h1);
        wr(12'h000, 32'h0);
        rd(12'h000, r); chk(r[0] == 1'b1, "R8", r[0], 1);
        wr(12'h000, 32'h12);
        rd(12'h000, r); chk(r[1] == 1'b0, "R8", r[1], 0);
        step(20);
        rd(12'h000, r);
        chk(r == 32'h44 && dom_switch_en == 2'b00, "R8", r, 32'h44);
    endtask

    task automatic t_tick_stall();
        logic [31:0] r;
        wr(12'h244, 32'h0404);
        periph_tick = 1'b0;
        wr(12'h000, 32'h20);
        step(30);
        rd(12'h000, r);
        chk(r[5] == 1'b1 && dom_switch_en[1] && dom_iso_en[1], "R9", {r[5], dom_switch_en[1], dom_iso_en[1]}, 3'b111);
        periph_tick = 1'b1;
        step(20);
        rd(12'h000, r);
        chk(r[5] == 1'b0 && !dom_iso_en[1], "R9", {r[5], dom_iso_en[1]}, 0);
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(3);
        @(negedge clk); rst = 1'b0;
        step(1);
        t_reset();
        t_regmap();
        wr(12'h268, 32'h0503);
        wr(12'h264, 32'h0702);
        t_gate_blocked();
        wr(12'h260, 32'h1);
        run_seq(0, 1'b0, 3, 5, "R4");
        run_seq(0, 1'b1, 2, 7, "R5");
        wr(12'h240, 32'h1);
        wr(12'h248, 32'h0);
        run_seq(1, 1'b0, 0, 0, "R4");
        wr(12'h244, 32'h3f3f);
        run_seq(1, 1'b1, 63, 63, "R5");
        run_seq(0, 1'b0, 3, 5, "R4");
        t_both_bits();
        t_busy_ignore();
        t_tick_stall();
        chk(iso_viol == 0, "R10", iso_viol, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule